// File: doc/BRIEF.md
# Partitioned Shared Cache Replacement Controller

This block models the tag side of a set-associative shared last-level cache whose ways can be split at run time between private groups and one common pool. A requester that runs under hard timing constraints asks for a number of ways. It then owns those way indices in every set until it gives them back. All ways that nobody owns form a single shared pool, and every requester allocates into that pool. Lookups carry a requester identifier, a real-time flag and a line address. The response comes one cycle later with the hit flag, the way that now holds the line, and the tag of any line that left the cache.

On a miss, a real-time requester that owns ways fills the least recently used way of its own group. The line pushed out of that group is not dropped: it moves into the least recently used way of the shared pool, so the private group always keeps its most recent lines. Other misses replace only within the shared pool. When a group is released, its lines stay valid. Those ways are then picked first as shared victims, ahead of any way that has been used since.

Top module: `psc_cache`

## Requirements
- R1: A synchronous active-high reset invalidates every line, drops every reservation, clears the released-way marks and ranks each set by way index, with way 0 most recent and the highest way least recent. The first shared miss to any set therefore fills the highest way, and `rsp_valid` and `cmd_rsp_valid` are 0 in the cycle after reset.
- R2: A lookup is accepted on a clock edge where `req_valid` and `req_ready` are both 1, and its response appears with `rsp_valid` = 1 in the following cycle. A hit searches every valid way of the set indexed by `req_addr[5:0]` against `req_addr[15:6]`, whoever owns the way. A hit reports that way and `rsp_evict_valid` = 0.
- R3: A reserve command (`cmd_release` = 0) for a requester asks for `cmd_size`+1 ways, which is 1 to 4. On success it claims the lowest-indexed unowned ways and answers `cmd_rsp_err` = 0 one cycle later.
- R4: A reserve is refused with `cmd_rsp_err` = 1 and no change of state in any of three cases: it would leave fewer than 2 unowned ways, the requester already owns ways, or 4 requesters already hold reservations.
- R5: A release (`cmd_release` = 1) of a requester that owns nothing answers `cmd_rsp_err` = 1. Otherwise it returns that requester's ways to the shared pool, and the lines held there stay valid and keep hitting.
- R6: Released ways are marked in every set and are chosen as shared victims first, lowest index first. A way loses its mark when it is hit or filled.
- R7: A real-time miss from a requester that owns ways fills the least recently used way of its own group. If that way held a valid line, the line moves into the shared victim way, and the line displaced there is reported as evicted.
- R8: A non-real-time miss, or a real-time miss from a requester with no reservation, replaces only the shared victim way, which is the least recently used unowned way when no released-way mark applies. Ways owned by any requester are never replaced by such a miss.
- R9: Each set keeps a full recency order. A hit or fill makes the way most recent, and the victim within a region is the least recent way of that region.
- R10: Commands take precedence over lookups: `req_ready` is 0 in any cycle where `cmd_valid` is 1, and `cmd_ready` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup can be accepted this cycle |
| req_id | input | 3 | Requester identifier |
| req_rt | input | 1 | Requester is real-time |
| req_addr | input | 16 | Line address: tag in [15:6], set index in [5:0] |
| rsp_valid | output | 1 | Lookup response present |
| rsp_hit | output | 1 | Line was found |
| rsp_way | output | 4 | Way that now holds the line |
| rsp_evict_valid | output | 1 | A valid line left the cache |
| rsp_evict_tag | output | 10 | Tag of the line that left the cache |
| cmd_valid | input | 1 | Reserve or release command present |
| cmd_ready | output | 1 | Command accepted (always 1) |
| cmd_release | input | 1 | 1 = release, 0 = reserve |
| cmd_id | input | 3 | Requester the command applies to |
| cmd_size | input | 2 | Ways requested minus one |
| cmd_rsp_valid | output | 1 | Command response present |
| cmd_rsp_err | output | 1 | Command was refused |

## Verification
The hardest case to reach is a real-time miss that pushes a valid private line into a shared pool whose least recent way is also valid. That needs a full private group, a shared pool shrunk to two ways and a known recency order, all at once. The stimulus reaches it by reserving ways for four requesters until exactly two unowned ways remain. It then fills one group through a chain of real-time misses to a single set, with each way's rank worked out step by step. Later lookups confirm that the moved line still hits, that non-real-time misses cycle only through the two shared ways, and that released ways are chosen before older unmarked ways.

// File: rtl/psc_pkg.sv
package psc_pkg;
    localparam int WAYS       = 16;
    localparam int SETS       = 64;
    localparam int ADDR_W     = 16;
    localparam int ID_W       = 3;
    localparam int MAX_HOLD   = 4;
    localparam int MAX_RSV    = 4;
    localparam int MIN_SHARED = 2;

    localparam int WAY_W  = $clog2(WAYS);
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - IDX_W;
    localparam int SZ_W   = $clog2(MAX_RSV);
    localparam int HOLD_W = $clog2(MAX_HOLD + 1);

    typedef logic [WAY_W-1:0]            way_t;
    typedef logic [TAG_W-1:0]            tag_t;
    typedef logic [IDX_W-1:0]            idx_t;
    typedef logic [ID_W-1:0]             id_t;
    typedef logic [WAY_W-1:0][WAYS-1:0]  dummy_t;
    typedef way_t [WAYS-1:0]             age_vec_t;

    typedef struct packed {
        logic hit;
        way_t way;
        logic ev_valid;
        tag_t ev_tag;
    } rsp_t;

    // Make way w most recent; every way that was more recent ages by one.
    function automatic age_vec_t age_touch(input age_vec_t a, input way_t w);
        age_vec_t r;
        r = a;
        for (int i = 0; i < WAYS; i++) begin
            if (a[i] < a[w]) r[i] = a[i] + 1'b1;
        end
        r[w] = '0;
        return r;
    endfunction
endpackage

// File: rtl/psc_victim.sv
module psc_victim
    import psc_pkg::*;
(
    input  age_vec_t           ages,
    input  logic [WAYS-1:0]    mask,
    input  logic [WAYS-1:0]    marked,
    output way_t               way
);
    logic found;
    way_t best_age;

    always_comb begin
        way      = '0;
        found    = 1'b0;
        best_age = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (marked[w] && !found) begin
                way   = way_t'(w);
                found = 1'b1;
            end
        end
        if (!found) begin
            for (int w = 0; w < WAYS; w++) begin
                if (mask[w] && (!found || ages[w] > best_age)) begin
                    way      = way_t'(w);
                    best_age = ages[w];
                    found    = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/psc_owner_table.sv
module psc_owner_table
    import psc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_fire,
    input  logic                 cmd_release,
    input  id_t                  cmd_id,
    input  logic [SZ_W-1:0]      cmd_size,
    output logic                 cmd_rsp_valid,
    output logic                 cmd_rsp_err,
    output logic [WAYS-1:0]      owned,
    output id_t [WAYS-1:0]       way_id,
    output logic                 rel_pulse,
    output logic [WAYS-1:0]      rel_mask
);
    logic [HOLD_W-1:0] hold_cnt;
    logic [WAYS-1:0]   mine;
    logic [WAYS-1:0]   claim;
    logic              holds;
    logic              rsv_ok;
    int                shared_cnt;
    int                need;
    int                taken;

    always_comb begin
        for (int w = 0; w < WAYS; w++) mine[w] = owned[w] && (way_id[w] == cmd_id);
        holds      = |mine;
        shared_cnt = WAYS - $countones(owned);
        need       = int'(cmd_size) + 1;
        rsv_ok     = !holds && (int'(hold_cnt) < MAX_HOLD) && (shared_cnt >= need + MIN_SHARED);
        claim      = '0;
        taken      = 0;
        for (int w = 0; w < WAYS; w++) begin
            if (!owned[w] && taken < need) begin
                claim[w] = 1'b1;
                taken    = taken + 1;
            end
        end
        rel_pulse = cmd_fire && cmd_release && holds;
        rel_mask  = mine;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            owned         <= '0;
            way_id        <= '0;
            hold_cnt      <= '0;
            cmd_rsp_valid <= 1'b0;
            cmd_rsp_err   <= 1'b0;
        end else begin
            cmd_rsp_valid <= cmd_fire;
            if (cmd_fire) begin
                if (cmd_release) begin
                    cmd_rsp_err <= !holds;
                    if (holds) begin
                        owned    <= owned & ~mine;
                        hold_cnt <= hold_cnt - 1'b1;
                    end
                end else begin
                    cmd_rsp_err <= !rsv_ok;
                    if (rsv_ok) begin
                        owned    <= owned | claim;
                        hold_cnt <= hold_cnt + 1'b1;
                        for (int w = 0; w < WAYS; w++)
                            if (claim[w]) way_id[w] <= cmd_id;
                    end
                end
            end
        end
    end

    // R4: reservations never shrink the shared pool below its floor
    assert_min_shared_R4: assert property (@(posedge clk) disable iff (rst)
        (WAYS - $countones(owned)) >= MIN_SHARED);

    // R4: holder count stays within the limit
    assert_hold_limit_R4: assert property (@(posedge clk) disable iff (rst)
        int'(hold_cnt) <= MAX_HOLD);

    // R4: a refused command leaves the ownership map untouched
    assert_refuse_stable_R4: assert property (@(posedge clk) disable iff (rst)
        cmd_rsp_valid && cmd_rsp_err |-> $stable(owned));
endmodule

// File: rtl/psc_cache.sv
module psc_cache
    import psc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ID_W-1:0]   req_id,
    input  logic              req_rt,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [WAY_W-1:0]  rsp_way,
    output logic              rsp_evict_valid,
    output logic [TAG_W-1:0]  rsp_evict_tag,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_release,
    input  logic [ID_W-1:0]   cmd_id,
    input  logic [SZ_W-1:0]   cmd_size,
    output logic              cmd_rsp_valid,
    output logic              cmd_rsp_err
);
    tag_t            tag_q   [SETS][WAYS];
    logic [WAYS-1:0] valid_q [SETS];
    logic [WAYS-1:0] stale_q [SETS];
    age_vec_t        age_q   [SETS];

    logic [WAYS-1:0] owned, rel_mask, priv_mask, shared_mask, hit_vec;
    id_t [WAYS-1:0]  way_id;
    logic            rel_pulse, acc, hit, use_priv;
    idx_t            idx;
    tag_t            tag;
    tag_t            cur_tags [WAYS];
    logic [WAYS-1:0] cur_valid, cur_stale, n_valid, n_stale;
    age_vec_t        cur_ages, n_ages;
    way_t            hit_way, pv, sv;
    logic            wa_en, wb_en;
    way_t            wa_way, wb_way;
    tag_t            wa_tag, wb_tag;
    rsp_t            r, rsp_q;

    assign req_ready = !cmd_valid;
    assign cmd_ready = 1'b1;
    assign acc       = req_valid && req_ready;
    assign idx       = req_addr[IDX_W-1:0];
    assign tag       = req_addr[ADDR_W-1:IDX_W];

    psc_owner_table u_owners (
        .clk(clk), .rst(rst), .cmd_fire(cmd_valid), .cmd_release(cmd_release),
        .cmd_id(cmd_id), .cmd_size(cmd_size), .cmd_rsp_valid(cmd_rsp_valid),
        .cmd_rsp_err(cmd_rsp_err), .owned(owned), .way_id(way_id),
        .rel_pulse(rel_pulse), .rel_mask(rel_mask)
    );

    generate
        for (genvar g = 0; g < WAYS; g++) begin : g_way
            assign cur_tags[g]    = tag_q[idx][g];
            assign hit_vec[g]     = cur_valid[g] && (cur_tags[g] == tag);
            assign priv_mask[g]   = owned[g] && (way_id[g] == req_id);
            assign shared_mask[g] = !owned[g];
        end
    endgenerate

    assign cur_valid = valid_q[idx];
    assign cur_stale = stale_q[idx];
    assign cur_ages  = age_q[idx];
    assign hit       = |hit_vec;
    assign use_priv  = req_rt && (|priv_mask);

    always_comb begin
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) if (hit_vec[w]) hit_way = way_t'(w);
    end

    psc_victim u_vpriv (.ages(cur_ages), .mask(priv_mask),   .marked('0),                       .way(pv));
    psc_victim u_vshr  (.ages(cur_ages), .mask(shared_mask), .marked(cur_stale & shared_mask), .way(sv));

    always_comb begin
        n_ages  = cur_ages;
        n_valid = cur_valid;
        n_stale = cur_stale;
        wa_en = 1'b0; wa_way = '0; wa_tag = '0;
        wb_en = 1'b0; wb_way = '0; wb_tag = '0;
        r = '0;
        if (hit) begin
            r.hit            = 1'b1;
            r.way            = hit_way;
            n_ages           = age_touch(cur_ages, hit_way);
            n_stale[hit_way] = 1'b0;
        end else if (use_priv) begin
            r.way = pv;
            if (cur_valid[pv]) begin
                r.ev_valid  = cur_valid[sv];
                r.ev_tag    = cur_valid[sv] ? cur_tags[sv] : '0;
                wb_en       = 1'b1;
                wb_way      = sv;
                wb_tag      = cur_tags[pv];
                n_valid[sv] = 1'b1;
                n_stale[sv] = 1'b0;
                n_ages      = age_touch(n_ages, sv);
            end
            wa_en       = 1'b1;
            wa_way      = pv;
            wa_tag      = tag;
            n_valid[pv] = 1'b1;
            n_stale[pv] = 1'b0;
            n_ages      = age_touch(n_ages, pv);
        end else begin
            r.way       = sv;
            r.ev_valid  = cur_valid[sv];
            r.ev_tag    = cur_valid[sv] ? cur_tags[sv] : '0;
            wa_en       = 1'b1;
            wa_way      = sv;
            wa_tag      = tag;
            n_valid[sv] = 1'b1;
            n_stale[sv] = 1'b0;
            n_ages      = age_touch(cur_ages, sv);
        end
    end

    always_ff @(posedge clk) begin
        if (acc && wa_en) tag_q[idx][wa_way] <= wa_tag;
        if (acc && wb_en) tag_q[idx][wb_way] <= wb_tag;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_q     <= '0;
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                stale_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) age_q[s][w] <= way_t'(w);
            end
        end else begin
            rsp_valid <= acc;
            if (acc) begin
                rsp_q        <= r;
                age_q[idx]   <= n_ages;
                valid_q[idx] <= n_valid;
                stale_q[idx] <= n_stale;
            end
            if (rel_pulse) begin
                for (int s = 0; s < SETS; s++) stale_q[s] <= stale_q[s] | rel_mask;
            end
        end
    end

    assign rsp_hit         = rsp_q.hit;
    assign rsp_way         = rsp_q.way;
    assign rsp_evict_valid = rsp_q.ev_valid;
    assign rsp_evict_tag   = rsp_q.ev_tag;

    // R2: a response only follows an accepted lookup
    assert_rsp_after_accept_R2: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid && req_ready));

    // R2: a hit never reports an eviction
    assert_hit_no_evict_R2: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_hit |-> !rsp_evict_valid);

    // R8: shared-path misses replace an unowned way only
    assert_shared_victim_unowned_R8: assert property (@(posedge clk) disable iff (rst)
        acc && !hit && !use_priv |-> !owned[sv]);

    // R7: private-path misses replace a way of the requester's own group
    assert_priv_victim_owned_R7: assert property (@(posedge clk) disable iff (rst)
        acc && !hit && use_priv |-> priv_mask[pv]);

    // R10: a command cycle never also yields a lookup response
    assert_cmd_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(rsp_valid && cmd_rsp_valid));
endmodule

// File: tb/sim_psc_cache.sv
module sim_psc_cache;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;
    localparam logic [1:0] K_L = 2'd0, K_R = 2'd1, K_F = 2'd2;

    typedef struct packed {
        logic [1:0] kind;
        logic [2:0] id;
        logic       rt;
        logic [1:0] sz;
        logic [9:0] tag;
        logic [5:0] idx;
        logic       ehit;
        logic [3:0] eway;
        logic       eev;
        logic [9:0] etag;
        logic       eerr;
        logic [3:0] rq;
    } vec_t;

    localparam int NV = 31;
    localparam vec_t TBL [NV] = '{
        '{K_L,3'd0,1'b0,2'd0,10'd5 ,6'd0,1'b0,4'd15,1'b0,10'd0 ,1'b0,4'd1 }, // R1 first miss -> way 15
        '{K_L,3'd0,1'b0,2'd0,10'd6 ,6'd0,1'b0,4'd14,1'b0,10'd0 ,1'b0,4'd9 }, // R9 next oldest
        '{K_L,3'd0,1'b0,2'd0,10'd5 ,6'd0,1'b1,4'd15,1'b0,10'd0 ,1'b0,4'd2 }, // R2 hit
        '{K_R,3'd1,1'b0,2'd3,10'd0 ,6'd0,1'b0,4'd0 ,1'b0,10'd0 ,1'b0,4'd3 }, // R3 ways 0-3
        '{K_R,3'd2,1'b0,2'd3,10'd0 ,6'd0,1'b0,4'd0 ,1'b0,10'd0 ,1'b0,4'd3 }, // R3 ways 4-7
        '{K_R,3'd3,1'b0,2'd3,10'd0 ,6'd0,1'b0,4'd0 ,1'b0,10'd0 ,1'b0,4'd3 }, // R3 ways 8-11
        '{K_R,3'd4,1'b0,2'd3,10'd0 ,6'd0,1'b0,4'd0 ,1'b0,10'd0 ,1'b1,4'd4 }, // R4 would leave 0
        '{K_R,3'd4,1'b0,2'd1,10'd0 ,6'd0,1'b0,4'd0 ,1'b0,10'd0 ,1'b0,4'd3 }, // R3 ways 12-13
        '{K_R,3'd5,1'b0,2'd0,10'd0 ,6'd0,1'b0,4'd0 ,1'b0,10'd0 ,1'b1,4'd4 }, // R4 space and holders
        '{K_F,3'd6,1'b0,2'd0,10'd0 ,6'd0,1'b0,4'd0 ,1'b0,10'd0 ,1'b1,4'd5 }, // R5 nothing held
        '{K_L,3'd1,1'b1,2'd0,10'd7 ,6'd0,1'b0,4'd3 ,1'b0,10'd0 ,1'b0,4'd7 }, // R7 private fill
        '{K_L,3'd1,1'b1,2'd0,10'd8 ,6'd0,1'b0,4'd2 ,1'b0,10'd0 ,1'b0,4'd7 },
        '{K_L,3'd1,1'b1,2'd0,10'd9 ,6'd0,1'b0,4'd1 ,1'b0,10'd0 ,1'b0,4'd7 },
        '{K_L,3'd1,1'b1,2'd0,10'd10,6'd0,1'b0,4'd0 ,1'b0,10'd0 ,1'b0,4'd9 }, // R9 group LRU order
        '{K_L,3'd1,1'b1,2'd0,10'd11,6'd0,1'b0,4'd3 ,1'b1,10'd6 ,1'b0,4'd7 }, // R7 demote, evict 6
        '{K_L,3'd1,1'b1,2'd0,10'd7 ,6'd0,1'b1,4'd14,1'b0,10'd0 ,1'b0,4'd7 }, // R7 moved line hits
        '{K_L,3'd7,1'b0,2'd0,10'd12,6'd0,1'b0,4'd15,1'b1,10'd5 ,1'b0,4'd8 }, // R8 shared only
        '{K_L,3'd7,1'b0,2'd0,10'd13,6'd0,1'b0,4'd14,1'b1,10'd7 ,1'b0,4'd8 }, // R8 private untouched
        '{K_L,3'd2,1'b0,2'd0,10'd10,6'd0,1'b1,4'd0 ,1'b0,10'd0 ,1'b0,4'd2 }, // R2 hit in other's group
        '{K_L,3'd2,1'b1,2'd0,10'd14,6'd0,1'b0,4'd7 ,1'b0,10'd0 ,1'b0,4'd7 }, // R7 group of id 2
        '{K_L,3'd5,1'b1,2'd0,10'd15,6'd0,1'b0,4'd15,1'b1,10'd12,1'b0,4'd8 }, // R8 rt without group
        '{K_F,3'd1,1'b0,2'd0,10'd0 ,6'd0,1'b0,4'd0 ,1'b0,10'd0 ,1'b0,4'd5 }, // R5 release ok
        '{K_L,3'd7,1'b0,2'd0,10'd16,6'd0,1'b0,4'd0 ,1'b1,10'd10,1'b0,4'd6 }, // R6 released first
        '{K_L,3'd7,1'b0,2'd0,10'd9 ,6'd0,1'b1,4'd1 ,1'b0,10'd0 ,1'b0,4'd5 }, // R5 line kept
        '{K_L,3'd7,1'b0,2'd0,10'd17,6'd0,1'b0,4'd2 ,1'b1,10'd8 ,1'b0,4'd6 }, // R6 next marked
        '{K_F,3'd1,1'b0,2'd0,10'd0 ,6'd0,1'b0,4'd0 ,1'b0,10'd0 ,1'b1,4'd5 }, // R5 double release
        '{K_R,3'd2,1'b0,2'd0,10'd0 ,6'd0,1'b0,4'd0 ,1'b0,10'd0 ,1'b1,4'd4 }, // R4 already holds
        '{K_R,3'd6,1'b0,2'd2,10'd0 ,6'd0,1'b0,4'd0 ,1'b0,10'd0 ,1'b0,4'd3 }, // R3 ways 0-2
        '{K_R,3'd7,1'b0,2'd0,10'd0 ,6'd0,1'b0,4'd0 ,1'b0,10'd0 ,1'b1,4'd4 }, // R4 holder limit
        '{K_L,3'd6,1'b1,2'd0,10'd18,6'd5,1'b0,4'd2 ,1'b0,10'd0 ,1'b0,4'd3 }, // R3 claimed 0-2
        '{K_L,3'd6,1'b1,2'd0,10'd19,6'd5,1'b0,4'd1 ,1'b0,10'd0 ,1'b0,4'd9 }  // R9
    };

    logic clk = 1'b0, rst = 1'b1;
    logic req_valid = 1'b0, req_rt = 1'b0, cmd_valid = 1'b0, cmd_release = 1'b0;
    logic [2:0] req_id = '0, cmd_id = '0;
    logic [15:0] req_addr = '0;
    logic [1:0] cmd_size = '0;
    logic req_ready, rsp_valid, rsp_hit, rsp_evict_valid, cmd_ready, cmd_rsp_valid, cmd_rsp_err;
    logic [3:0] rsp_way;
    logic [9:0] rsp_evict_tag;
    int n_chk = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    psc_cache u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_id(req_id), .req_rt(req_rt), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
        .rsp_evict_valid(rsp_evict_valid), .rsp_evict_tag(rsp_evict_tag),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_release(cmd_release),
        .cmd_id(cmd_id), .cmd_size(cmd_size), .cmd_rsp_valid(cmd_rsp_valid),
        .cmd_rsp_err(cmd_rsp_err)
    );

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic lookup(input logic [2:0] id, input logic rt, input logic [9:0] tg,
                          input logic [5:0] ix, input logic eh, input logic [3:0] ew,
                          input logic ee, input logic [9:0] et, input string rq);
        @(negedge clk);
        req_id = id; req_rt = rt; req_addr = {tg, ix}; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(rq, {16'd0, rsp_valid, rsp_hit, rsp_way, rsp_evict_valid,
                   rsp_evict_valid ? rsp_evict_tag : 10'd0},
                  {16'd0, 1'b1, eh, ew, ee, ee ? et : 10'd0});
    endtask

    task automatic command(input logic rel, input logic [2:0] id, input logic [1:0] sz,
                           input logic ee, input string rq);
        @(negedge clk);
        cmd_release = rel; cmd_id = id; cmd_size = sz; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        check(rq, {30'd0, cmd_rsp_valid, cmd_rsp_err}, {30'd0, 1'b1, ee});
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 / R10: idle outputs after reset
        check("R1", {30'd0, rsp_valid, cmd_rsp_valid}, 32'd0);
        check("R10", {30'd0, req_ready, cmd_ready}, 32'd3);

        for (int i = 0; i < NV; i++) begin
            string rq;
            rq = $sformatf("R%0d", TBL[i].rq);
            if (TBL[i].kind == K_L)
                lookup(TBL[i].id, TBL[i].rt, TBL[i].tag, TBL[i].idx, TBL[i].ehit,
                       TBL[i].eway, TBL[i].eev, TBL[i].etag, rq);
            else
                command(TBL[i].kind == K_F, TBL[i].id, TBL[i].sz, TBL[i].eerr, rq);
        end

        // R10: command and lookup presented together; command wins
        @(negedge clk);
        req_id = 3'd7; req_rt = 1'b0; req_addr = {10'd20, 6'd3}; req_valid = 1'b1;
        cmd_release = 1'b0; cmd_id = 3'd7; cmd_size = 2'd0; cmd_valid = 1'b1;
        #1;
        check("R10", {31'd0, req_ready}, 32'd0);
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R10", {29'd0, rsp_valid, cmd_rsp_valid, cmd_rsp_err}, {29'd0, 3'b011});
        @(negedge clk);
        req_valid = 1'b0;
        // R6: held lookup now served; released way 3 is the marked shared victim
        check("R6", {16'd0, rsp_valid, rsp_hit, rsp_way, rsp_evict_valid, 10'd0},
                    {16'd0, 1'b1, 1'b0, 4'd3, 1'b0, 10'd0});

        // R1: reset mid-run clears lines and reservations
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check("R1", {30'd0, rsp_valid, cmd_rsp_valid}, 32'd0);
        lookup(3'd0, 1'b0, 10'd5, 6'd0, 1'b0, 4'd15, 1'b0, 10'd0, "R1");
        lookup(3'd6, 1'b1, 10'd21, 6'd0, 1'b0, 4'd14, 1'b0, 10'd0, "R1");

        finish_run();
    end
endmodule